// File: doc/BRIEF.md
# Synchronous buck gate-drive sequencer

This block sits between a phase controller and the gate drivers of one synchronous buck phase. A decoded three-level PWM command arrives each clock. The block turns it into a high-side and a low-side gate enable and never lets the two overlap. Every hand-over between the switches passes through a parameterised dead time with both gates off.

A mid-level (floating) command holds the last switch state for a short while. If the mid level lasts beyond a hold-off window, both switches are released. With diode emulation enabled, the low side is cut off once a blanking window has elapsed and the zero-crossing comparator reports reverse or zero inductor current. The cut stays in force until the next high command. A disable input and an undervoltage flag force both gates off at once. A digital junction-temperature code drives a warning output with hysteresis, and this warning does not stop switching.

Top module: `buck_gate_seq`

## Requirements
- R1: A high command (`pwm_cmd` = 2'b01) first clears `ls_gate` and then sets `hs_gate` once the dead time has run out.
- R2: A low command (`pwm_cmd` = 2'b00) first clears `hs_gate` and then sets `ls_gate` once the dead time has run out.
- R3: `hs_gate` and `ls_gate` are never both high in the same cycle. Between one gate falling and the other rising, both stay low for exactly `DEAD_CYC` cycles.
- R4: A mid command (`pwm_cmd` = 2'b10 or 2'b11) lasting `HOLD_CYC` cycles or fewer leaves the gates as they were. A mid command held for `HOLD_CYC`+2 cycles has both gates low at the end of that run.
- R5: After a hold-off release, a new high or low command turns on the matching gate through the normal interlock, with no extra wait when the dead time has already elapsed.
- R6: While `stage_on` is 0, both gates are low from the next clock edge on, whatever the command. Only a logic 1 on `stage_on` allows switching, so a pulled-down open input keeps the stage off.
- R7: While `supply_low` is 1 (logic supply under its lockout threshold), both gates are low from the next clock edge on.
- R8: With `de_en_n` = 0 and a low command, the low side turns on normally. A `zc_flag` of 1 (inductor current at or below zero) is ignored for `BLANK_CYC` cycles of the low level. After that it clears `ls_gate`.
- R9: Once diode emulation has cut the low side, `ls_gate` stays low while the command stays low, even if `zc_flag` returns to 0. The next high command clears the cut.
- R10: With `de_en_n` = 1, `zc_flag` has no effect and the low side conducts for the whole low command.
- R11: `thw_n` goes to 0 the cycle after `temp_code` (unsigned, 1 LSB = 1 °C) exceeds `TEMP_SET` (160). It returns to 1 only after the code falls below `TEMP_CLR` (135), and it holds its value in between. The gates keep switching while it is 0.
- R12: While `rst` is high, `hs_gate` = 0, `ls_gate` = 0 and `thw_n` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_cmd | input | 2 | Decoded PWM level: 00 low, 01 high, 10/11 mid |
| stage_on | input | 1 | Active-low disable: 0 forces both gates off |
| de_en_n | input | 1 | 0 enables diode emulation, 1 forces continuous conduction |
| zc_flag | input | 1 | Zero-crossing comparator, 1 = inductor current at or below zero |
| supply_low | input | 1 | Undervoltage lockout flag, 1 = supply too low |
| temp_code | input | TEMP_W | Junction temperature code in °C |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| thw_n | output | 1 | Thermal warning, 0 = over temperature |

## Verification
The command patterns are high-to-low and low-to-high hand-overs, which show the dead-time count exactly. Mid pulses of exactly the hold-off length and of two cycles more separate holding from release. A mid release followed by a fresh level checks re-entry. Low commands with diode emulation on and off, with the zero-crossing flag raised inside and after the blanking window and then dropped, tell the blanking, the cut, the latched cut and the ignored flag apart. Temperature codes on both sides of each threshold and between them show set, hold and clear. Disable, lockout and reset are applied while a gate is on.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_MID  = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_HS   = 2'b01,
    REQ_LS   = 2'b10
  } req_e;

  function automatic lvl_e decode_lvl(input logic [1:0] code);
    case (code)
      2'b00:   return LVL_LOW;
      2'b01:   return LVL_HIGH;
      default: return LVL_MID;
    endcase
  endfunction

endpackage

// File: rtl/seq_level_timer.sv
module seq_level_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic count_en,
  output logic done
);
  localparam int CW = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  // counter resets whenever the watched level is absent
  always_ff @(posedge clk) begin
    if (rst || !count_en) begin
      cnt <= '0;
    end else if (cnt < LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/seq_mode_ctrl.sv
module seq_mode_ctrl
  import buck_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  lvl_e lvl,
  input  logic hold_done,
  input  logic blank_done,
  input  logic de_act,
  input  logic zc_flag,
  output logic want_hs,
  output logic want_ls
);
  req_e last_req;
  logic de_cut;
  logic ls_ok;

  assign ls_ok = !(de_act && de_cut);

  always_comb begin
    want_hs = 1'b0;
    want_ls = 1'b0;
    case (lvl)
      LVL_HIGH: want_hs = 1'b1;
      LVL_LOW:  want_ls = ls_ok;
      default: begin
        if (!hold_done) begin
          if (last_req == REQ_HS) begin
            want_hs = 1'b1;
          end else if (last_req == REQ_LS) begin
            want_ls = ls_ok;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_req <= REQ_NONE;
      de_cut   <= 1'b0;
    end else begin
      case (lvl)
        LVL_HIGH: begin
          last_req <= REQ_HS;
          de_cut   <= 1'b0;
        end
        LVL_LOW: begin
          last_req <= REQ_LS;
          if (de_act && blank_done && zc_flag) begin
            de_cut <= 1'b1;
          end
        end
        default: begin
          if (hold_done) begin
            last_req <= REQ_NONE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/seq_gate_interlock.sv
module seq_gate_interlock #(
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic force_off,
  input  logic want_hs,
  input  logic want_ls,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] LIM = CW'(DEAD_CYC - 1);

  logic [CW-1:0] off_cnt;
  logic          gap_ok;
  logic          hs_n;
  logic          ls_n;

  assign gap_ok = !hs_gate && !ls_gate && (off_cnt >= LIM);

  always_comb begin
    hs_n = 1'b0;
    ls_n = 1'b0;
    if (!force_off) begin
      if (want_hs) begin
        hs_n = hs_gate | gap_ok;
      end else if (want_ls) begin
        ls_n = ls_gate | gap_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_gate <= 1'b0;
      ls_gate <= 1'b0;
      off_cnt <= '0;
    end else begin
      hs_gate <= hs_n;
      ls_gate <= ls_n;
      if (hs_gate || ls_gate) begin
        off_cnt <= '0;
      end else if (off_cnt < LIM) begin
        off_cnt <= off_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_thermal_flag.sv
module seq_thermal_flag #(
  parameter int TEMP_W   = 8,
  parameter int TEMP_SET = 160,
  parameter int TEMP_CLR = 135
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              thw_n
);
  localparam logic [TEMP_W-1:0] SET_C = TEMP_W'(TEMP_SET);
  localparam logic [TEMP_W-1:0] CLR_C = TEMP_W'(TEMP_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      thw_n <= 1'b1;
    end else if (temp_code > SET_C) begin
      thw_n <= 1'b0;
    end else if (temp_code < CLR_C) begin
      thw_n <= 1'b1;
    end
  end
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import buck_seq_pkg::*;
#(
  parameter int DEAD_CYC  = 3,
  parameter int HOLD_CYC  = 8,
  parameter int BLANK_CYC = 5,
  parameter int TEMP_W    = 8,
  parameter int TEMP_SET  = 160,
  parameter int TEMP_CLR  = 135
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pwm_cmd,
  input  logic              stage_on,
  input  logic              de_en_n,
  input  logic              zc_flag,
  input  logic              supply_low,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hs_gate,
  output logic              ls_gate,
  output logic              thw_n
);
  lvl_e lvl_q;
  logic hold_done;
  logic blank_done;
  logic want_hs;
  logic want_ls;
  logic force_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= LVL_MID;
    end else begin
      lvl_q <= decode_lvl(pwm_cmd);
    end
  end

  assign force_off = !stage_on || supply_low;

  seq_level_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .count_en (lvl_q == LVL_MID),
    .done     (hold_done)
  );

  seq_level_timer #(.LIMIT(BLANK_CYC)) u_blank (
    .clk      (clk),
    .rst      (rst),
    .count_en (lvl_q == LVL_LOW),
    .done     (blank_done)
  );

  seq_mode_ctrl u_mode (
    .clk        (clk),
    .rst        (rst),
    .lvl        (lvl_q),
    .hold_done  (hold_done),
    .blank_done (blank_done),
    .de_act     (!de_en_n),
    .zc_flag    (zc_flag),
    .want_hs    (want_hs),
    .want_ls    (want_ls)
  );

  seq_gate_interlock #(.DEAD_CYC(DEAD_CYC)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .force_off (force_off),
    .want_hs   (want_hs),
    .want_ls   (want_ls),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate)
  );

  seq_thermal_flag #(
    .TEMP_W   (TEMP_W),
    .TEMP_SET (TEMP_SET),
    .TEMP_CLR (TEMP_CLR)
  ) u_therm (
    .clk       (clk),
    .rst       (rst),
    .temp_code (temp_code),
    .thw_n     (thw_n)
  );
endmodule

// File: rtl/buck_gate_seq_chk.sv
module buck_gate_seq_chk #(
  parameter int DEAD_CYC = 3,
  parameter int TEMP_W   = 8,
  parameter int TEMP_SET = 160,
  parameter int TEMP_CLR = 135
) (
  input logic              clk,
  input logic              rst,
  input logic              stage_on,
  input logic              supply_low,
  input logic [TEMP_W-1:0] temp_code,
  input logic              hs_gate,
  input logic              ls_gate,
  input logic              thw_n
);
  localparam int GW = $clog2(DEAD_CYC + 1);
  localparam logic [GW-1:0] GMAX = GW'(DEAD_CYC);

  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst || hs_gate || ls_gate) begin
      gap_cnt <= '0;
    end else if (gap_cnt < GMAX) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate));

  // R3
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_gate) || $rose(ls_gate)) |-> (gap_cnt >= GMAX));

  // R6
  disable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !stage_on |=> (!hs_gate && !ls_gate));

  // R7
  lockout_off_chk: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> (!hs_gate && !ls_gate));

  // R11
  therm_set_chk: assert property (@(posedge clk) disable iff (rst)
    (temp_code > TEMP_W'(TEMP_SET)) |=> !thw_n);

  // R11
  therm_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (temp_code < TEMP_W'(TEMP_CLR)) |=> thw_n);

  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!hs_gate && !ls_gate && thw_n));
endmodule

bind buck_gate_seq buck_gate_seq_chk #(
  .DEAD_CYC (DEAD_CYC),
  .TEMP_W   (TEMP_W),
  .TEMP_SET (TEMP_SET),
  .TEMP_CLR (TEMP_CLR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stage_on   (stage_on),
  .supply_low (supply_low),
  .temp_code  (temp_code),
  .hs_gate    (hs_gate),
  .ls_gate    (ls_gate),
  .thw_n      (thw_n)
);

// File: tb/buck_gate_seq_test.sv
module buck_gate_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pwm_cmd = 2'b10;
  logic       stage_on = 1'b1;
  logic       de_en_n = 1'b1;
  logic       zc_flag = 1'b0;
  logic       supply_low = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic       hs_gate;
  logic       ls_gate;
  logic       thw_n;

  int checks = 0;
  int errors = 0;
  int overlaps = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  buck_gate_seq uut (
    .clk        (clk),
    .rst        (rst),
    .pwm_cmd    (pwm_cmd),
    .stage_on   (stage_on),
    .de_en_n    (de_en_n),
    .zc_flag    (zc_flag),
    .supply_low (supply_low),
    .temp_code  (temp_code),
    .hs_gate    (hs_gate),
    .ls_gate    (ls_gate),
    .thw_n      (thw_n)
  );

  typedef struct packed {
    logic [1:0] pwm;
    logic       on;
    logic       den_n;
    logic       zc;
    logic       uv;
    logic [7:0] temp;
    logic [7:0] cyc;
    logic       e_hs;
    logic       e_ls;
    logic       e_thw;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [0:NV-1] = '{
    '{2'b01,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd2,1'b1,1'b0,1'b1,8'd1},  // R1
    '{2'b00,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd2,1'b0,1'b0,1'b1,8'd2},  // R2
    '{2'b00,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd2,1'b0,1'b0,1'b1,8'd3},  // R3
    '{2'b00,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd1,1'b0,1'b1,1'b1,8'd3},  // R3
    '{2'b01,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd2,1'b0,1'b0,1'b1,8'd1},  // R1
    '{2'b01,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd2,1'b0,1'b0,1'b1,8'd3},  // R3
    '{2'b01,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd1,1'b1,1'b0,1'b1,8'd3},  // R3
    '{2'b10,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd8,1'b1,1'b0,1'b1,8'd4},  // R4
    '{2'b01,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd3,1'b1,1'b0,1'b1,8'd4},  // R4
    '{2'b10,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd9,1'b1,1'b0,1'b1,8'd4},  // R4
    '{2'b11,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd1,1'b0,1'b0,1'b1,8'd4},  // R4
    '{2'b10,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd5,1'b0,1'b0,1'b1,8'd4},  // R4
    '{2'b00,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd2,1'b0,1'b1,1'b1,8'd5},  // R5
    '{2'b01,1'b1,1'b0,1'b0,1'b0,8'd25, 8'd6,1'b1,1'b0,1'b1,8'd1},  // R1
    '{2'b00,1'b1,1'b0,1'b1,1'b0,8'd25, 8'd4,1'b0,1'b0,1'b1,8'd8},  // R8
    '{2'b00,1'b1,1'b0,1'b1,1'b0,8'd25, 8'd1,1'b0,1'b1,1'b1,8'd8},  // R8
    '{2'b00,1'b1,1'b0,1'b1,1'b0,8'd25, 8'd2,1'b0,1'b1,1'b1,8'd8},  // R8
    '{2'b00,1'b1,1'b0,1'b1,1'b0,8'd25, 8'd1,1'b0,1'b0,1'b1,8'd8},  // R8
    '{2'b00,1'b1,1'b0,1'b0,1'b0,8'd25, 8'd4,1'b0,1'b0,1'b1,8'd9},  // R9
    '{2'b01,1'b1,1'b0,1'b0,1'b0,8'd25, 8'd2,1'b1,1'b0,1'b1,8'd9},  // R9
    '{2'b00,1'b1,1'b1,1'b1,1'b0,8'd25, 8'd5,1'b0,1'b1,1'b1,8'd10}, // R10
    '{2'b00,1'b1,1'b1,1'b1,1'b0,8'd25, 8'd8,1'b0,1'b1,1'b1,8'd10}, // R10
    '{2'b00,1'b0,1'b1,1'b0,1'b0,8'd25, 8'd1,1'b0,1'b0,1'b1,8'd6},  // R6
    '{2'b01,1'b0,1'b1,1'b0,1'b0,8'd25, 8'd4,1'b0,1'b0,1'b1,8'd6},  // R6
    '{2'b01,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd2,1'b1,1'b0,1'b1,8'd6},  // R6
    '{2'b01,1'b1,1'b1,1'b0,1'b1,8'd25, 8'd1,1'b0,1'b0,1'b1,8'd7},  // R7
    '{2'b00,1'b1,1'b1,1'b0,1'b0,8'd25, 8'd3,1'b0,1'b1,1'b1,8'd7},  // R7
    '{2'b00,1'b1,1'b1,1'b0,1'b0,8'd160,8'd2,1'b0,1'b1,1'b1,8'd11}, // R11
    '{2'b00,1'b1,1'b1,1'b0,1'b0,8'd161,8'd1,1'b0,1'b1,1'b0,8'd11}, // R11
    '{2'b00,1'b1,1'b1,1'b0,1'b0,8'd135,8'd2,1'b0,1'b1,1'b0,8'd11}, // R11
    '{2'b00,1'b1,1'b1,1'b0,1'b0,8'd134,8'd1,1'b0,1'b1,1'b1,8'd11}, // R11
    '{2'b00,1'b1,1'b1,1'b0,1'b0,8'd150,8'd2,1'b0,1'b1,1'b1,8'd11}  // R11
  };

  task automatic check_out(input string tag, input logic e_hs, input logic e_ls,
                           input logic e_thw);
    checks++;
    if (hs_gate !== e_hs || ls_gate !== e_ls || thw_n !== e_thw) begin
      errors++;
      $display("FAIL %s hs/ls/thw got %b%b%b expected %b%b%b", tag,
               hs_gate, ls_gate, thw_n, e_hs, e_ls, e_thw);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && hs_gate && ls_gate) overlaps++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_out("R12 reset", 1'b0, 1'b0, 1'b1);
    rst = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check_out("R12 idle after reset", 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      pwm_cmd    = VECS[i].pwm;
      stage_on   = VECS[i].on;
      de_en_n    = VECS[i].den_n;
      zc_flag    = VECS[i].zc;
      supply_low = VECS[i].uv;
      temp_code  = VECS[i].temp;
      repeat (int'(VECS[i].cyc)) @(posedge clk);
      @(negedge clk);
      check_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                VECS[i].e_hs, VECS[i].e_ls, VECS[i].e_thw);
    end

    // R11: warning set while the low side keeps conducting
    temp_code = 8'd200;
    @(posedge clk);
    @(negedge clk);
    check_out("R11 hot while switching", 1'b0, 1'b1, 1'b0);

    // R12: reset in mid operation
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_out("R12 reset while running", 1'b0, 1'b0, 1'b1);

    // R2: restart after reset, dead time counted from reset
    rst = 1'b0;
    pwm_cmd = 2'b00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_out("R2 restart waits dead time", 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check_out("R2 restart low side on", 1'b0, 1'b1, 1'b0);

    // R3: no cycle with both gates high across the run
    checks++;
    if (overlaps != 0) begin
      errors++;
      $display("FAIL R3 overlap cycles got %0d expected 0", overlaps);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule